// File: doc/BRIEF.md
# Write-Once System Configuration Register

An 8-bit configuration register on a plain CPU-style bus (select, write strobe, write data, read data). Three of its bits are ordinary read/write controls. The other five are guarded: they take a single write, and only during the first 64 clock cycles after reset is released. After that write, or once those 64 cycles have passed, they are read-only until the next reset. This protects early system setup from accidental changes made later by runaway software.

A special-mode input, used for test and factory setup, lifts the guard. While it is high, the guarded bits may be written at any time and any number of times. The register drives its value on a configuration output. It also reports whether the write window is still open, and which bits are currently read-only.

Bit map, most significant bit first:
- bit 7: converter power enable (free)
- bit 6: converter clock source (free)
- bit 5: interrupt edge select (guarded)
- bit 4: oscillator start delay (guarded)
- bit 3: clock monitor enable (free)
- bit 2: forced clock monitor (guarded)
- bits 1:0: rate select (guarded)

Top module: `cfg_guard_reg`

## Requirements
- R1: While reset is held and just after it is released, the register holds 8'h10, `window_open` is 1 and `locked_bits` is 8'h00.
- R2: The free bits 7, 6 and 3 take the value of `wdata` on every write (`sel` and `wr_en` high at a clock edge), in any mode and at any time.
- R3: In normal mode, the first write at any of the clock edges numbered 0 to 63 after reset release updates the guarded bits 5, 4, 2, 1 and 0 from `wdata`.
- R4: A normal-mode write inside the window locks the whole guarded group, whatever its data. Later normal-mode writes leave bits 5, 4, 2, 1 and 0 unchanged, while their free bits still update.
- R5: From clock edge 64 after reset release, `window_open` is 0 and stays 0. Normal-mode writes then leave the guarded bits unchanged.
- R6: While `special_mode` is 1, every write updates all eight bits, regardless of the window or the lock, and such writes do not set the lock.
- R7: `rdata` equals the full current register value while `sel` is 1 and is 8'h00 while `sel` is 0. Without a write, the register keeps its value.
- R8: `locked_bits` is 8'h37 when `special_mode` is 0 and the group is locked or the window has closed. Otherwise it is 8'h00.
- R9: Asserting reset at any time clears the lock, reopens the window and restores 8'h10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select |
| wr_en | input | 1 | Write strobe, qualified by `sel` |
| wdata | input | 8 | Write data |
| special_mode | input | 1 | High lifts write protection |
| rdata | output | 8 | Read data, zero when not selected |
| cfg_out | output | 8 | Current register value |
| window_open | output | 1 | High during the first 64 cycles after reset |
| locked_bits | output | 8 | Mask of bits that are currently read-only |

## Verification
A write takes effect at the clock edge where `sel` and `wr_en` are high, and it is visible on `cfg_out` and on `locked_bits` one edge later. `rdata` and the lock mask follow `sel` and `special_mode` combinationally, in the same cycle. The bench drives inputs on the falling edge and samples on the next falling edge after the write edge. It counts idle cycles from reset release so that a write lands exactly on edge 63 or edge 64, which places the window boundary on a known cycle.

// File: rtl/cfg_guard_reg.sv
module cfg_guard_reg #(
  parameter int W = 8,
  parameter int WINDOW = 64,
  parameter logic [W-1:0] PROT_MASK = 8'h37,
  parameter logic [W-1:0] RST_VAL = 8'h10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         special_mode,
  output logic [W-1:0] rdata,
  output logic [W-1:0] cfg_out,
  output logic         window_open,
  output logic [W-1:0] locked_bits
);
  localparam int CW = $clog2(WINDOW + 1);

  logic [CW-1:0] cnt;
  logic          grp_locked;
  logic [W-1:0]  cfg_q;
  logic          wr, prot_ok;
  logic [W-1:0]  wmask;

  assign wr          = sel & wr_en;
  assign window_open = cnt < CW'(WINDOW);
  assign prot_ok     = special_mode | (window_open & ~grp_locked);
  assign wmask       = prot_ok ? {W{1'b1}} : ~PROT_MASK;

  // window counter saturates at WINDOW
  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (window_open) cnt <= cnt + 1'b1;
  end

  // a normal-mode write inside the window locks the guarded group
  always_ff @(posedge clk) begin
    if (!rst_n)                                 grp_locked <= 1'b0;
    else if (wr && !special_mode && window_open) grp_locked <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= RST_VAL;
    else if (wr) cfg_q <= (cfg_q & ~wmask) | (wdata & wmask);
  end

  assign cfg_out     = cfg_q;
  assign rdata       = sel ? cfg_q : '0;
  assign locked_bits = (!special_mode && (grp_locked || !window_open)) ? PROT_MASK : '0;

  AST_FREE_BITS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((cfg_out & ~PROT_MASK) == ($past(wdata) & ~PROT_MASK))); // R2
  AST_GUARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !special_mode && (grp_locked || !window_open)) |=>
      ((cfg_out & PROT_MASK) == ($past(cfg_out) & PROT_MASK))); // R4
  AST_WINDOW_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    !window_open |=> !window_open); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    grp_locked |=> grp_locked); // R4
  AST_SPECIAL_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && special_mode) |=> (cfg_out == $past(wdata))); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg_out)); // R7
endmodule

// File: tb/cfg_guard_reg_tb.sv
module cfg_guard_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr_en = 1'b0, special_mode = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, cfg_out, locked_bits;
  logic window_open;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_guard_reg dut_i (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
    .special_mode(special_mode), .rdata(rdata), .cfg_out(cfg_out),
    .window_open(window_open), .locked_bits(locked_bits));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; sel = 0; wr_en = 0; special_mode = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    sel = 1; wr_en = 1; wdata = d;
    @(negedge clk);
    sel = 0; wr_en = 0;
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0; @(negedge clk);
    chk("R1 value in reset", cfg_out, 8'h10);
    do_reset();
    chk("R1 value after reset", cfg_out, 8'h10);
    chk("R1 window open", {7'b0, window_open}, 8'h01);
    chk("R1 locked mask", locked_bits, 8'h00);
  endtask

  task automatic t_lock();
    do_reset();
    wr(8'hFF);
    chk("R3 first write", cfg_out, 8'hFF);
    chk("R8 mask after lock", locked_bits, 8'h37);
    wr(8'h00);
    chk("R4 locked guarded, free cleared", cfg_out, 8'h37);
    wr(8'hC8);
    chk("R2 free bits after lock", cfg_out, 8'hFF);
  endtask

  task automatic t_window_last();
    do_reset();
    idle(63);
    chk("R5 window still open at 63", {7'b0, window_open}, 8'h01);
    wr(8'h25);
    chk("R3 write on edge 63", cfg_out, 8'h25);
  endtask

  task automatic t_window_closed();
    do_reset();
    idle(64);
    chk("R5 window closed at 64", {7'b0, window_open}, 8'h00);
    chk("R8 mask when closed", locked_bits, 8'h37);
    wr(8'hEA);
    chk("R5 guarded ignored after window", cfg_out, 8'hD8);
    idle(5);
    chk("R5 window stays closed", {7'b0, window_open}, 8'h00);
  endtask

  task automatic t_special();
    do_reset();
    idle(70);
    special_mode = 1;
    @(negedge clk);
    chk("R8 mask in special mode", locked_bits, 8'h00);
    wr(8'h07);
    chk("R6 special write 1", cfg_out, 8'h07);
    wr(8'h30);
    chk("R6 special write 2", cfg_out, 8'h30);
    special_mode = 0;
    wr(8'h00);
    chk("R5 back to normal, closed", cfg_out, 8'h30);
  endtask

  task automatic t_special_no_lock();
    do_reset();
    special_mode = 1;
    wr(8'h01);
    chk("R6 special write in window", cfg_out, 8'h01);
    special_mode = 0;
    @(negedge clk);
    chk("R6 no lock from special write", locked_bits, 8'h00);
    wr(8'h02);
    chk("R3 normal write after special", cfg_out, 8'h02);
    wr(8'h00);
    chk("R4 lock after normal write", cfg_out, 8'h02);
  endtask

  task automatic t_read();
    do_reset();
    wr(8'h9A);
    sel = 1;
    #1;
    chk("R7 read selected", rdata, 8'h9A);
    sel = 0;
    #1;
    chk("R7 read unselected", rdata, 8'h00);
    idle(3);
    chk("R7 value held", cfg_out, 8'h9A);
  endtask

  task automatic t_reset_mid();
    do_reset();
    idle(10);
    wr(8'hFF);
    do_reset();
    chk("R9 value restored", cfg_out, 8'h10);
    chk("R9 lock cleared", locked_bits, 8'h00);
    chk("R9 window reopened", {7'b0, window_open}, 8'h01);
    wr(8'h03);
    chk("R9 guarded writable again", cfg_out, 8'h03);
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_lock();
        t_window_last();
        t_window_closed();
        t_special();
        t_special_no_lock();
        t_read();
        t_reset_mid();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule